// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one compute multiprocessor and decides, one request at a time, whether a new thread block can be made resident there. It keeps four running totals: how many blocks are resident, how many threads they hold, how many register-file bytes they claim and how many shared-memory bytes they claim. A block is made resident only when every one of these totals, plus the new block's share, stays within its capacity. All of a block's context must be resident for its whole life, so nothing is granted in part.

A request gives the thread count, the registers used per thread and the shared-memory bytes. The register claim is threads times registers per thread times four bytes. Some requests can never run, for example one with more threads than one block may hold. These are consumed at once and answered with an error. A legal request that does not fit yet is held off by keeping ready low until enough resources are handed back. When a block retires, the release channel is given the same descriptor as the one it was admitted with. An admit and a release in the same cycle both take effect. The status output shows, at every cycle, how the request now offered would be treated, and the four totals are brought out as ports.

Top module: `block_admission_ctrl`

## Requirements
- R1: No more than 32 blocks are ever resident; with 16-thread blocks the 33rd request waits even though only 512 threads are in use.
- R2: The resident thread total never exceeds 2048; a legal request that would push it past 2048 waits.
- R3: A request with zero threads or more than 1024 threads is taken at once (ready high), answered with an error and never changes any total.
- R4: The register claim is threads x registers per thread x 4 bytes; admission needs claimed plus requested to be at most 262144 bytes, and an exact fill is admitted.
- R5: Admission needs claimed plus requested shared memory to be at most 167936 bytes, and an exact fill is admitted.
- R6: A legal request that does not fit now holds req_ready low, shows status 2 and leaves all totals unchanged until a release makes room; it is then admitted.
- R7: A request whose register claim alone exceeds 262144 bytes, or whose shared memory alone exceeds 167936 bytes, is answered with an error and never admitted.
- R8: A release subtracts one block, its threads, its register claim and its shared bytes on the next edge; an admit and a release in the same cycle are both applied.
- R9: A release while no block is resident is ignored and all totals stay zero.
- R10: The cycle after a handshake, resp_valid is high for one cycle with resp_code 1 for an admit or 3 for an error.
- R11: status reads 0 with no request, 1 when the offered request would be admitted, 2 when it must wait and 3 when it is in error; after reset all totals read zero and resp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A block request is offered |
| req_ready | output | 1 | Request taken this cycle (admitted or rejected as an error) |
| req_threads | input | 12 | Threads in the requested block |
| req_regs_per_thr | input | 8 | Registers used by each thread |
| req_shmem_bytes | input | 18 | Shared-memory bytes for the block |
| rel_valid | input | 1 | A resident block retires |
| rel_threads | input | 12 | Threads of the retiring block |
| rel_regs_per_thr | input | 8 | Registers per thread of the retiring block |
| rel_shmem_bytes | input | 18 | Shared-memory bytes of the retiring block |
| status | output | 2 | 0 idle, 1 admissible, 2 wait, 3 error |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_code | output | 2 | 1 admitted, 3 error |
| used_blocks | output | 6 | Resident block count |
| used_threads | output | 12 | Resident thread count |
| used_reg_bytes | output | 19 | Register bytes claimed |
| used_shmem_bytes | output | 18 | Shared-memory bytes claimed |

## Verification
Each resource is driven to its limit alone while the others keep plenty of room: many 16-thread blocks for the block count, two maximum-size blocks for threads, one register-heavy block for the register file and two shared-memory blocks that fill it exactly. This shows which comparison holds a request back, and that an exact fill is admitted where one more byte is not. Illegal descriptors of each kind (zero threads, too many threads, register or shared claims beyond capacity) must be consumed with an error and leave the totals untouched. A release in the same cycle as an admit, and a release with nothing resident, show whether both updates land together and whether the totals can go below zero.

// File: rtl/bac_pkg.sv
package bac_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ADMIT  = 2'd1,
      ST_WAIT   = 2'd2,
      ST_CFGERR = 2'd3
   } adm_status_e;

   typedef enum logic [1:0] {
      RSP_NONE   = 2'd0,
      RSP_ACCEPT = 2'd1,
      RSP_RSVD   = 2'd2,
      RSP_ERROR  = 2'd3
   } adm_resp_e;

endpackage

// File: rtl/bac_demand_calc.sv
// Register-file bytes claimed by one block descriptor.
module bac_demand_calc #(
   parameter int THR_W         = 12,
   parameter int RPT_W         = 8,
   parameter int BYTES_PER_REG = 4,
   parameter int DEM_W         = THR_W + RPT_W + $clog2(BYTES_PER_REG) + 1
) (
   input  logic [THR_W-1:0] threads,
   input  logic [RPT_W-1:0] regs_per_thr,
   output logic [DEM_W-1:0] reg_bytes
);
   localparam int PROD_W = THR_W + RPT_W;
   localparam int SHIFT  = $clog2(BYTES_PER_REG);

   logic [PROD_W-1:0] reg_count;

   always_comb begin
      reg_count = PROD_W'(threads) * PROD_W'(regs_per_thr);
   end

   generate
      if ((BYTES_PER_REG & (BYTES_PER_REG - 1)) == 0) begin : g_pow2
         always_comb reg_bytes = DEM_W'(reg_count) << SHIFT;
      end else begin : g_mul
         always_comb reg_bytes = DEM_W'(reg_count) * DEM_W'(BYTES_PER_REG);
      end
   endgenerate

endmodule

// File: rtl/bac_usage_lane.sv
// One tracked resource: running total, room test and admit/release update.
module bac_usage_lane #(
   parameter int              CNT_W = 12,
   parameter int              AMT_W = 12,
   parameter longint unsigned LIMIT = 2048
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AMT_W-1:0] need_amt,
   input  logic             add_en,
   input  logic             sub_en,
   input  logic [AMT_W-1:0] sub_amt,
   output logic [CNT_W-1:0] used,
   output logic             room
);
   localparam int WIDE  = (CNT_W > AMT_W) ? CNT_W : AMT_W;
   localparam int SUM_W = WIDE + 2;

   logic [CNT_W-1:0] used_q;
   logic [SUM_W-1:0] nxt;

   initial begin
      if (LIMIT >= (64'd1 << CNT_W))
         $error("bac_usage_lane: LIMIT does not fit in CNT_W bits");
   end

   always_comb begin
      room = (SUM_W'(used_q) + SUM_W'(need_amt)) <= SUM_W'(LIMIT);
   end

   always_comb begin
      nxt = SUM_W'(used_q);
      if (add_en) nxt = nxt + SUM_W'(need_amt);
      if (sub_en) nxt = nxt - SUM_W'(sub_amt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) used_q <= '0;
      else        used_q <= nxt[CNT_W-1:0];
   end

   assign used = used_q;

endmodule

// File: rtl/block_admission_ctrl.sv
module block_admission_ctrl
   import bac_pkg::*;
#(
   parameter int              MAX_BLOCKS      = 32,
   parameter int              MAX_THREADS     = 2048,
   parameter int              MAX_BLK_THREADS = 1024,
   parameter longint unsigned REG_BYTES       = 262144,
   parameter longint unsigned SHM_BYTES       = 167936,
   parameter int              BYTES_PER_REG   = 4,
   parameter int              THR_W           = 12,
   parameter int              RPT_W           = 8,
   parameter int              SHM_W           = 18
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req_valid,
   output logic                                  req_ready,
   input  logic [THR_W-1:0]                      req_threads,
   input  logic [RPT_W-1:0]                      req_regs_per_thr,
   input  logic [SHM_W-1:0]                      req_shmem_bytes,
   input  logic                                  rel_valid,
   input  logic [THR_W-1:0]                      rel_threads,
   input  logic [RPT_W-1:0]                      rel_regs_per_thr,
   input  logic [SHM_W-1:0]                      rel_shmem_bytes,
   output logic [1:0]                            status,
   output logic                                  resp_valid,
   output logic [1:0]                            resp_code,
   output logic [$clog2(MAX_BLOCKS+1)-1:0]       used_blocks,
   output logic [$clog2(MAX_THREADS+1)-1:0]      used_threads,
   output logic [$clog2(REG_BYTES+1)-1:0]        used_reg_bytes,
   output logic [$clog2(SHM_BYTES+1)-1:0]        used_shmem_bytes
);
   localparam int BLK_CW = $clog2(MAX_BLOCKS + 1);
   localparam int THR_CW = $clog2(MAX_THREADS + 1);
   localparam int REG_CW = $clog2(REG_BYTES + 1);
   localparam int SHM_CW = $clog2(SHM_BYTES + 1);
   localparam int DEM_W  = THR_W + RPT_W + $clog2(BYTES_PER_REG) + 1;

   // Parameter sanity, checked once at start of elaboration/simulation.
   initial begin
      if (MAX_BLK_THREADS > MAX_THREADS)
         $error("block_admission_ctrl: per-block thread cap above total cap");
      if ((64'd1 << THR_W) <= 64'(MAX_BLK_THREADS))
         $error("block_admission_ctrl: THR_W too narrow for per-block cap");
      if ((64'd1 << SHM_W) <= SHM_BYTES)
         $error("block_admission_ctrl: SHM_W too narrow for capacity");
      if (BYTES_PER_REG < 1)
         $error("block_admission_ctrl: BYTES_PER_REG must be positive");
   end

   // ---------------- demand of request and release ----------------
   logic [DEM_W-1:0] req_reg_bytes;
   logic [DEM_W-1:0] rel_reg_bytes;

   bac_demand_calc #(
      .THR_W(THR_W), .RPT_W(RPT_W), .BYTES_PER_REG(BYTES_PER_REG), .DEM_W(DEM_W)
   ) u_req_dem (
      .threads(req_threads), .regs_per_thr(req_regs_per_thr), .reg_bytes(req_reg_bytes)
   );

   bac_demand_calc #(
      .THR_W(THR_W), .RPT_W(RPT_W), .BYTES_PER_REG(BYTES_PER_REG), .DEM_W(DEM_W)
   ) u_rel_dem (
      .threads(rel_threads), .regs_per_thr(rel_regs_per_thr), .reg_bytes(rel_reg_bytes)
   );

   // ---------------- legality (permanent) ----------------
   logic legal;
   always_comb begin
      legal = (req_threads != '0)
           && (64'(req_threads)     <= 64'(MAX_BLK_THREADS))
           && (64'(req_reg_bytes)   <= REG_BYTES)
           && (64'(req_shmem_bytes) <= SHM_BYTES);
   end

   // ---------------- resource lanes ----------------
   logic admit;
   logic rel_take;
   logic blk_room, thr_room, reg_room, shm_room;
   logic room_all;

   assign rel_take = rel_valid && (used_blocks != '0);

   bac_usage_lane #(.CNT_W(BLK_CW), .AMT_W(1), .LIMIT(longint'(MAX_BLOCKS))) u_lane_blk (
      .clk(clk), .rst_n(rst_n), .need_amt(1'b1), .add_en(admit),
      .sub_en(rel_take), .sub_amt(1'b1), .used(used_blocks), .room(blk_room)
   );

   bac_usage_lane #(.CNT_W(THR_CW), .AMT_W(THR_W), .LIMIT(longint'(MAX_THREADS))) u_lane_thr (
      .clk(clk), .rst_n(rst_n), .need_amt(req_threads), .add_en(admit),
      .sub_en(rel_take), .sub_amt(rel_threads), .used(used_threads), .room(thr_room)
   );

   bac_usage_lane #(.CNT_W(REG_CW), .AMT_W(DEM_W), .LIMIT(REG_BYTES)) u_lane_reg (
      .clk(clk), .rst_n(rst_n), .need_amt(req_reg_bytes), .add_en(admit),
      .sub_en(rel_take), .sub_amt(rel_reg_bytes), .used(used_reg_bytes), .room(reg_room)
   );

   bac_usage_lane #(.CNT_W(SHM_CW), .AMT_W(SHM_W), .LIMIT(SHM_BYTES)) u_lane_shm (
      .clk(clk), .rst_n(rst_n), .need_amt(req_shmem_bytes), .add_en(admit),
      .sub_en(rel_take), .sub_amt(rel_shmem_bytes), .used(used_shmem_bytes), .room(shm_room)
   );

   assign room_all = blk_room && thr_room && reg_room && shm_room;

   // ---------------- decision ----------------
   adm_status_e st;
   always_comb begin
      if (!req_valid)     st = ST_IDLE;
      else if (!legal)    st = ST_CFGERR;
      else if (room_all)  st = ST_ADMIT;
      else                st = ST_WAIT;
   end

   assign status    = st;
   assign req_ready = (st == ST_ADMIT) || (st == ST_CFGERR);
   assign admit     = (st == ST_ADMIT);

   // ---------------- response ----------------
   adm_resp_e rsp_q;
   logic      rsp_v_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_v_q <= 1'b0;
         rsp_q   <= RSP_NONE;
      end else begin
         rsp_v_q <= req_ready;
         if (admit)          rsp_q <= RSP_ACCEPT;
         else if (req_ready) rsp_q <= RSP_ERROR;
         else                rsp_q <= RSP_NONE;
      end
   end

   assign resp_valid = rsp_v_q;
   assign resp_code  = rsp_q;

endmodule

// File: rtl/bac_admit_checker.sv
module bac_admit_checker #(
   parameter int              MAX_BLOCKS  = 32,
   parameter int              MAX_THREADS = 2048,
   parameter longint unsigned REG_BYTES   = 262144,
   parameter longint unsigned SHM_BYTES   = 167936,
   parameter int              BLK_CW      = 6,
   parameter int              THR_CW      = 12,
   parameter int              REG_CW      = 19,
   parameter int              SHM_CW      = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rel_valid,
   input logic [1:0]        status,
   input logic              resp_valid,
   input logic [1:0]        resp_code,
   input logic [BLK_CW-1:0] used_blocks,
   input logic [THR_CW-1:0] used_threads,
   input logic [REG_CW-1:0] used_reg_bytes,
   input logic [SHM_CW-1:0] used_shmem_bytes
);

   assert_block_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      64'(used_blocks) <= 64'(MAX_BLOCKS));

   assert_thread_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      64'(used_threads) <= 64'(MAX_THREADS));

   assert_reg_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      64'(used_reg_bytes) <= REG_BYTES);

   assert_shm_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      64'(used_shmem_bytes) <= SHM_BYTES);

   assert_err_not_admitted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && status == 2'd3) |=> (used_blocks <= $past(used_blocks)));

   assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !rel_valid) |=>
         ($stable(used_blocks) && $stable(used_threads)
          && $stable(used_reg_bytes) && $stable(used_shmem_bytes)));

   assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (resp_valid && (resp_code == 2'd1 || resp_code == 2'd3)));

   assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !resp_valid);

endmodule

bind block_admission_ctrl bac_admit_checker #(
   .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS),
   .REG_BYTES(REG_BYTES), .SHM_BYTES(SHM_BYTES),
   .BLK_CW($clog2(MAX_BLOCKS+1)), .THR_CW($clog2(MAX_THREADS+1)),
   .REG_CW($clog2(REG_BYTES+1)), .SHM_CW($clog2(SHM_BYTES+1))
) u_admit_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rel_valid(rel_valid), .status(status), .resp_valid(resp_valid),
   .resp_code(resp_code), .used_blocks(used_blocks), .used_threads(used_threads),
   .used_reg_bytes(used_reg_bytes), .used_shmem_bytes(used_shmem_bytes)
);

// File: tb/block_admission_ctrl_tb_top.sv
`timescale 1ns/1ps
module block_admission_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [11:0] req_threads = '0;
   logic [7:0]  req_regs_per_thr = '0;
   logic [17:0] req_shmem_bytes = '0;
   logic        rel_valid = 1'b0;
   logic [11:0] rel_threads = '0;
   logic [7:0]  rel_regs_per_thr = '0;
   logic [17:0] rel_shmem_bytes = '0;
   logic [1:0]  status;
   logic        resp_valid;
   logic [1:0]  resp_code;
   logic [5:0]  used_blocks;
   logic [11:0] used_threads;
   logic [18:0] used_reg_bytes;
   logic [17:0] used_shmem_bytes;

   int checks = 0;
   int failures = 0;
   int m_blk = 0, m_thr = 0, m_reg = 0, m_shm = 0;
   logic [1:0] exp_q[$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   block_admission_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_threads(req_threads), .req_regs_per_thr(req_regs_per_thr),
      .req_shmem_bytes(req_shmem_bytes), .rel_valid(rel_valid),
      .rel_threads(rel_threads), .rel_regs_per_thr(rel_regs_per_thr),
      .rel_shmem_bytes(rel_shmem_bytes), .status(status), .resp_valid(resp_valid),
      .resp_code(resp_code), .used_blocks(used_blocks), .used_threads(used_threads),
      .used_reg_bytes(used_reg_bytes), .used_shmem_bytes(used_shmem_bytes)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_usage(string tag);
      chk({tag, " blocks"},  int'(used_blocks),      m_blk);
      chk({tag, " threads"}, int'(used_threads),     m_thr);
      chk({tag, " regs"},    int'(used_reg_bytes),   m_reg);
      chk({tag, " shmem"},   int'(used_shmem_bytes), m_shm);
   endtask

   // monitor: pops expected response codes as responses appear
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         if (exp_q.size() == 0) begin
            chk("R10 unexpected response", int'(resp_code), 0);
         end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            chk("R10 response code", int'(resp_code), int'(e));
         end
      end
   end

   task automatic drive_req(int t, int r, int s);
      req_threads      = 12'(t);
      req_regs_per_thr = 8'(r);
      req_shmem_bytes  = 18'(s);
      req_valid        = 1'b1;
      #0.2;
   endtask

   // waits for ready, pushes expected code, updates model, completes handshake
   task automatic complete_req(bit is_err);
      int guard = 0;
      while (!req_ready && guard < 200) begin
         @(negedge clk); #0.2;
         guard++;
      end
      chk("R6 request eventually taken", int'(req_ready), 1);
      exp_q.push_back(is_err ? 2'd3 : 2'd1);
      if (!is_err) begin
         m_blk++;
         m_thr += int'(req_threads);
         m_reg += int'(req_threads) * int'(req_regs_per_thr) * 4;
         m_shm += int'(req_shmem_bytes);
      end
      @(negedge clk); #0.2;
      req_valid = 1'b0;
   endtask

   task automatic send(int t, int r, int s, bit is_err);
      drive_req(t, r, s);
      complete_req(is_err);
   endtask

   task automatic set_rel(int t, int r, int s);
      rel_threads      = 12'(t);
      rel_regs_per_thr = 8'(r);
      rel_shmem_bytes  = 18'(s);
      rel_valid        = 1'b1;
      if (m_blk > 0) begin
         m_blk--;
         m_thr -= t;
         m_reg -= t * r * 4;
         m_shm -= s;
      end
   endtask

   task automatic release_blk(int t, int r, int s);
      set_rel(t, r, s);
      @(negedge clk); #0.2;
      rel_valid = 1'b0;
   endtask

   task automatic expect_wait(string tag, int cycles);
      for (int i = 0; i < cycles; i++) begin
         chk({tag, " ready low"}, int'(req_ready), 0);
         chk({tag, " status wait"}, int'(status), 2);
         chk_usage(tag);
         @(negedge clk); #0.2;
      end
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #0.2;
      // R11: reset state
      chk_usage("R11 reset");
      chk("R11 resp_valid after reset", int'(resp_valid), 0);
      chk("R11 status idle", int'(status), 0);
      chk("R11 ready idle", int'(req_ready), 0);
      rst_n = 1'b1;
      @(negedge clk); #0.2;

      // R9: release with nothing resident
      release_blk(1, 1, 0);
      @(negedge clk); #0.2;
      chk_usage("R9 release when empty");

      // R4/R11: basic admit
      drive_req(256, 32, 16384);
      chk("R11 status admissible", int'(status), 1);
      complete_req(1'b0);
      chk_usage("R4 basic admit");

      // R3/R7: illegal descriptors
      drive_req(1025, 1, 0);
      chk("R3 status error", int'(status), 3);
      chk("R3 ready high on error", int'(req_ready), 1);
      complete_req(1'b1);
      send(0, 1, 0, 1'b1);
      send(1024, 255, 0, 1'b1);
      send(1, 1, 200000, 1'b1);
      @(negedge clk); #0.2;
      chk_usage("R3 R7 errors leave totals");

      // R8: admit and release in the same cycle
      drive_req(128, 16, 1024);
      set_rel(256, 32, 16384);
      complete_req(1'b0);
      rel_valid = 1'b0;
      @(negedge clk); #0.2;
      chk_usage("R8 simultaneous");
      release_blk(128, 16, 1024);
      chk_usage("R8 release");

      // R1: block count limit with 16-thread blocks
      for (int i = 0; i < 32; i++) send(16, 8, 0, 1'b0);
      chk_usage("R1 32 small blocks");
      chk("R1 threads capped at 512", int'(used_threads), 512);
      drive_req(16, 8, 0);
      expect_wait("R1 33rd block", 3);
      release_blk(16, 8, 0);
      complete_req(1'b0);
      chk_usage("R6 admitted after release");
      for (int i = 0; i < 32; i++) release_blk(16, 8, 0);
      chk_usage("R8 all released");

      // R2: thread total limit
      send(1024, 1, 0, 1'b0);
      send(1024, 1, 0, 1'b0);
      chk_usage("R2 full threads");
      drive_req(1, 1, 0);
      expect_wait("R2 thread limit", 2);
      release_blk(1024, 1, 0);
      complete_req(1'b0);
      chk_usage("R2 after release");
      release_blk(1024, 1, 0);
      release_blk(1, 1, 0);

      // R4: register file exact fill then wait
      send(1024, 64, 0, 1'b0);
      chk("R4 exact register fill", int'(used_reg_bytes), 262144);
      drive_req(1, 1, 0);
      expect_wait("R4 register limit", 2);
      release_blk(1024, 64, 0);
      complete_req(1'b0);
      release_blk(1, 1, 0);
      chk_usage("R4 drained");

      // R5: shared memory exact fill then wait
      send(1, 1, 100000, 1'b0);
      send(1, 1, 67936, 1'b0);
      chk("R5 exact shared fill", int'(used_shmem_bytes), 167936);
      drive_req(1, 1, 1);
      expect_wait("R5 shared limit", 2);
      release_blk(1, 1, 100000);
      complete_req(1'b0);
      chk_usage("R5 after release");
      release_blk(1, 1, 67936);
      release_blk(1, 1, 1);
      chk_usage("R5 drained");

      repeat (3) @(negedge clk);
      chk("R10 all responses seen", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule